// File: doc/BRIEF.md
# UART Software Flow Control Engine

This block adds in-band Xon/Xoff flow control to a UART. It sits between the receive deserializer and the receive FIFO, and beside the transmit serializer. Each received character arrives as a one-cycle strobe. The engine compares the character with four programmable flow characters, masked to the current word length. In single mode one character forms a command. In double mode two consecutive characters form a command. A matched Xoff suspends the local transmitter once the character it is shifting out has finished. A matched Xon resumes it. Matched flow characters are dropped and are not written to the FIFO. Every other character is forwarded on a registered write port.

On the transmit side, the engine watches the receive FIFO fill level. When the level first reaches the halt threshold, it asks the transmitter to send Xoff (one or two characters). When the level later falls to the resume threshold, it asks for Xon. A pending injected character takes priority over ordinary FIFO data, but it is offered only while the serializer is idle. An optional special-character detector flags received characters that equal the second Xoff character, and still forwards them. A status flag and a maskable interrupt report Xoff and special-character hits.

Received strobes are expected at least two cycles apart, which any serial line guarantees.

Receive-side states: RX_IDLE, RX_HAVE_ON1 (first Xon character held), RX_HAVE_OFF1 (first Xoff character held) and RX_FLUSH (second held character being forwarded).
- RX_IDLE goes to RX_HAVE_ON1 or RX_HAVE_OFF1 on a first-character match in double mode.
- Either held state returns to RX_IDLE on a second-character match, or goes to RX_FLUSH on a mismatch.
- RX_FLUSH always returns to RX_IDLE.

Transmit-side states: TX_IDLE, TX_SEND_FIRST and TX_SEND_SECOND.
- TX_IDLE goes to TX_SEND_FIRST on a threshold crossing.
- TX_SEND_FIRST goes to TX_SEND_SECOND on acknowledge in double mode, otherwise to TX_IDLE.
- TX_SEND_SECOND goes to TX_IDLE on acknowledge.

Top module: `swfc_engine`

## Requirements
- R1: The four flow characters reset to 0x00 and are written through cfg_we with cfg_sel: 0 selects Xon1, 1 selects Xon2, 2 selects Xoff1 and 3 selects Xoff2.
- R2: With sw_en high and dbl_mode low, a character matching Xoff1 sets the suspended state and one matching Xon1 clears it. If both match, Xoff1 wins. Either kind of match is not written to the FIFO. Any other character appears on fifo_wr_en/fifo_wr_data one cycle after its strobe, in arrival order.
- R3: With dbl_mode high, suspension requires Xoff1 followed by Xoff2 on consecutive characters, and resumption requires Xon1 followed by Xon2. Neither character of a matched pair is written to the FIFO.
- R4: In double mode, if a first-character match is followed by a mismatch, the pair is abandoned. The held character is written one cycle after the second strobe, and the second character is written in the following cycle.
- R5: tx_permit falls one cycle after suspension, but only once tx_busy is low. While tx_busy stays high it stays high. It rises one cycle after an Xon match.
- R6: flow_flag is set by an Xoff match and cleared by an Xon match. irq equals flow_flag gated by int_en.
- R7: With spec_en high, a forwarded character equal to Xoff2 is still written to the FIFO and sets flow_flag.
- R8: Comparisons use only the low 5, 6, 7 or 8 bits, selected by wlen values 0, 1, 2 and 3.
- R9: With auto_en high, when fifo_level first reaches halt_lvl, the engine requests Xoff1 (then Xoff2 in double mode) on inj_req/inj_data. The request is made once per crossing, and each character is held until inj_ack.
- R10: After a halt, when fifo_level falls to resume_lvl or below, the engine requests Xon1 (then Xon2 in double mode) once.
- R11: inj_req is low while tx_busy is high, and tx_permit is low while an injected character is pending.
- R12: With sw_en low, every received character is forwarded and the transmitter is never suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_en | input | 1 | Enables receive-side Xon/Xoff matching |
| dbl_mode | input | 1 | Two-character flow commands when high |
| spec_en | input | 1 | Enables special-character detection |
| auto_en | input | 1 | Enables threshold-driven Xon/Xoff insertion |
| int_en | input | 1 | Interrupt enable for flow_flag |
| wlen | input | 2 | Word length: 0 gives 5 bits, up to 3 giving 8 bits |
| cfg_we | input | 1 | Flow character write strobe |
| cfg_sel | input | 2 | Flow character select (0 Xon1, 1 Xon2, 2 Xoff1, 3 Xoff2) |
| cfg_wdata | input | 8 | Flow character write data |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| fifo_level | input | LVL_W | Receive FIFO fill level |
| halt_lvl | input | LVL_W | Level at which Xoff is sent |
| resume_lvl | input | LVL_W | Level at which Xon is sent |
| tx_busy | input | 1 | Transmit serializer is shifting a character |
| inj_ack | input | 1 | Transmitter accepted the injected character |
| fifo_wr_en | output | 1 | Write strobe toward the receive FIFO |
| fifo_wr_data | output | 8 | Character written to the receive FIFO |
| tx_permit | output | 1 | Transmitter may start the next FIFO character |
| inj_req | output | 1 | Request to send an injected flow character |
| inj_data | output | 8 | Injected flow character |
| flow_flag | output | 1 | Xoff or special character seen |
| irq | output | 1 | Interrupt output |

## Verification
Each strobe is sampled on one clock edge. A forwarded character appears on the FIFO port, and the suspended state and flow_flag change, in the cycle right after that edge. The only exception is the second character of an abandoned pair, which appears one cycle later still. tx_permit reacts one further edge after suspension, and not until tx_busy is low. An injection request appears directly after the edge that samples a threshold crossing. The bench drives inputs 1 ns after a rising edge and checks status at that point, counting these latencies exactly. A monitor at each falling edge pops the scoreboard queue whenever a FIFO write is present, so order and drops are checked as they happen.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {RX_IDLE, RX_HAVE_ON1, RX_HAVE_OFF1, RX_FLUSH} rx_state_e;
    typedef enum logic [1:0] {TX_IDLE, TX_SEND_FIRST, TX_SEND_SECOND} tx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] xon1;
        logic [CHAR_W-1:0] xon2;
        logic [CHAR_W-1:0] xoff1;
        logic [CHAR_W-1:0] xoff2;
    } flow_chars_t;

    // wlen 0..3 selects 5..8 significant bits
    function automatic logic [CHAR_W-1:0] wlen_mask(input logic [1:0] wl);
        return {CHAR_W{1'b1}} >> (2'd3 - wl);
    endfunction
endpackage

// File: rtl/swfc_rx_matcher.sv
module swfc_rx_matcher
    import swfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_en,
    input  logic              dbl_mode,
    input  logic              spec_en,
    input  logic [1:0]        wlen,
    input  flow_chars_t       chars,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              fifo_wr_en,
    output logic [CHAR_W-1:0] fifo_wr_data,
    output logic              xoff_evt,
    output logic              xon_evt,
    output logic              special_evt,
    output rx_state_e         rx_state
);
    rx_state_e         state_q, state_d;
    logic [CHAR_W-1:0] hold_q, hold_d;
    logic [CHAR_W-1:0] mask;
    logic              on1, on2, off1, off2;
    logic              wr_d;
    logic [CHAR_W-1:0] wdata_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        mask    = wlen_mask(wlen);
        on1     = ((rx_data ^ chars.xon1)  & mask) == '0;
        on2     = ((rx_data ^ chars.xon2)  & mask) == '0;
        off1    = ((rx_data ^ chars.xoff1) & mask) == '0;
        off2    = ((rx_data ^ chars.xoff2) & mask) == '0;
        state_d = state_q;
        hold_d  = hold_q;
        wr_d    = 1'b0;
        wdata_d = rx_data;
        xoff_evt = 1'b0;
        xon_evt  = 1'b0;
        unique case (state_q)
            RX_IDLE: if (rx_valid) begin
                if (!sw_en) wr_d = 1'b1;
                else if (!dbl_mode) begin
                    if (off1)     xoff_evt = 1'b1;
                    else if (on1) xon_evt  = 1'b1;
                    else          wr_d     = 1'b1;
                end else if (off1) begin
                    hold_d = rx_data; state_d = RX_HAVE_OFF1;
                end else if (on1) begin
                    hold_d = rx_data; state_d = RX_HAVE_ON1;
                end else wr_d = 1'b1;
            end
            RX_HAVE_ON1, RX_HAVE_OFF1: if (rx_valid) begin
                if ((state_q == RX_HAVE_ON1) ? on2 : off2) begin
                    xon_evt  = (state_q == RX_HAVE_ON1);
                    xoff_evt = (state_q == RX_HAVE_OFF1);
                    state_d  = RX_IDLE;
                end else begin
                    wr_d    = 1'b1;
                    wdata_d = hold_q;
                    hold_d  = rx_data;
                    state_d = RX_FLUSH;
                end
            end
            RX_FLUSH: begin
                wr_d    = 1'b1;
                wdata_d = hold_q;
                state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
        special_evt = wr_d && spec_en && (((wdata_d ^ chars.xoff2) & mask) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q       <= '0;
            fifo_wr_en   <= 1'b0;
            fifo_wr_data <= '0;
        end else begin
            hold_q       <= hold_d;
            fifo_wr_en   <= wr_d;
            fifo_wr_data <= wdata_d;
        end
    end

    assign rx_state = state_q;
endmodule

// File: rtl/swfc_tx_inserter.sv
module swfc_tx_inserter
    import swfc_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_en,
    input  logic              dbl_mode,
    input  flow_chars_t       chars,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [LVL_W-1:0]  halt_lvl,
    input  logic [LVL_W-1:0]  resume_lvl,
    input  logic              tx_busy,
    input  logic              inj_ack,
    output logic              inj_pending,
    output logic              inj_req,
    output logic [CHAR_W-1:0] inj_data
);
    tx_state_e state_q, state_d;
    logic      over_q, over_d;
    logic      send_off_q, send_off_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= TX_IDLE;
            over_q     <= 1'b0;
            send_off_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            over_q     <= over_d;
            send_off_q <= send_off_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        over_d     = over_q;
        send_off_d = send_off_q;
        inj_pending = (state_q != TX_IDLE);
        inj_req     = inj_pending && !tx_busy;
        unique case (state_q)
            TX_IDLE: if (auto_en) begin
                if (!over_q && fifo_level >= halt_lvl) begin
                    over_d = 1'b1; send_off_d = 1'b1; state_d = TX_SEND_FIRST;
                end else if (over_q && fifo_level <= resume_lvl) begin
                    over_d = 1'b0; send_off_d = 1'b0; state_d = TX_SEND_FIRST;
                end
            end
            TX_SEND_FIRST:  if (inj_req && inj_ack) state_d = dbl_mode ? TX_SEND_SECOND : TX_IDLE;
            TX_SEND_SECOND: if (inj_req && inj_ack) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
        if (state_q == TX_SEND_SECOND) inj_data = send_off_q ? chars.xoff2 : chars.xon2;
        else                           inj_data = send_off_q ? chars.xoff1 : chars.xon1;
    end
endmodule

// File: rtl/swfc_engine.sv
module swfc_engine
    import swfc_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_en,
    input  logic              dbl_mode,
    input  logic              spec_en,
    input  logic              auto_en,
    input  logic              int_en,
    input  logic [1:0]        wlen,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CHAR_W-1:0] cfg_wdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [LVL_W-1:0]  halt_lvl,
    input  logic [LVL_W-1:0]  resume_lvl,
    input  logic              tx_busy,
    input  logic              inj_ack,
    output logic              fifo_wr_en,
    output logic [CHAR_W-1:0] fifo_wr_data,
    output logic              tx_permit,
    output logic              inj_req,
    output logic [CHAR_W-1:0] inj_data,
    output logic              flow_flag,
    output logic              irq
);
    flow_chars_t chars;
    logic        xoff_evt, xon_evt, special_evt;
    logic        suspended, permit_q, inj_pending;
    rx_state_e   rx_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chars <= '0;
        else if (cfg_we) begin
            unique case (cfg_sel)
                2'd0: chars.xon1  <= cfg_wdata;
                2'd1: chars.xon2  <= cfg_wdata;
                2'd2: chars.xoff1 <= cfg_wdata;
                2'd3: chars.xoff2 <= cfg_wdata;
                default: ;
            endcase
        end
    end

    swfc_rx_matcher u_rx (
        .clk, .rst_n, .sw_en, .dbl_mode, .spec_en, .wlen, .chars,
        .rx_valid, .rx_data, .fifo_wr_en, .fifo_wr_data,
        .xoff_evt, .xon_evt, .special_evt, .rx_state
    );

    swfc_tx_inserter #(.LVL_W(LVL_W)) u_tx (
        .clk, .rst_n, .auto_en, .dbl_mode, .chars, .fifo_level,
        .halt_lvl, .resume_lvl, .tx_busy, .inj_ack,
        .inj_pending, .inj_req, .inj_data
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            suspended <= 1'b0;
            flow_flag <= 1'b0;
            permit_q  <= 1'b1;
        end else begin
            if (xoff_evt)     suspended <= 1'b1;
            else if (xon_evt) suspended <= 1'b0;
            if (xoff_evt || special_evt) flow_flag <= 1'b1;
            else if (xon_evt)            flow_flag <= 1'b0;
            if (!suspended)    permit_q <= 1'b1;
            else if (!tx_busy) permit_q <= 1'b0;
        end
    end

    assign tx_permit = permit_q && !inj_pending;
    assign irq       = flow_flag && int_en;
endmodule

module swfc_engine_chk
    import swfc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sw_en,
    input logic              dbl_mode,
    input logic [1:0]        wlen,
    input flow_chars_t       chars,
    input logic              rx_valid,
    input logic [CHAR_W-1:0] rx_data,
    input logic              fifo_wr_en,
    input rx_state_e         rx_state,
    input logic              suspended,
    input logic              permit_q,
    input logic              tx_busy,
    input logic              flow_flag,
    input logic              inj_req,
    input logic              inj_ack,
    input logic              cfg_we,
    input logic [CHAR_W-1:0] inj_data
);
    logic [CHAR_W-1:0] m;
    assign m = {CHAR_W{1'b1}} >> (2'd3 - wlen);

    // R2: single-mode Xoff suspends and is dropped
    a_r2_xoff_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && sw_en && !dbl_mode && rx_state == RX_IDLE && ((rx_data ^ chars.xoff1) & m) == '0)
        |=> (suspended && !fifo_wr_en));

    // R3: first character of a double-mode command is held back
    a_r3_first_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && sw_en && dbl_mode && rx_state == RX_IDLE &&
         ((((rx_data ^ chars.xoff1) & m) == '0) || (((rx_data ^ chars.xon1) & m) == '0)))
        |=> !fifo_wr_en);

    // R5: permit only falls when the serializer was idle
    a_r5_stop_after_char: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(permit_q) |-> !$past(tx_busy));

    // R6: resumption leaves the flag clear
    a_r6_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(suspended) |-> !flow_flag);

    // R9: an unacknowledged injected character stays put
    a_r9_inj_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_req && !inj_ack && !cfg_we) |=> $stable(inj_data));
endmodule

bind swfc_engine swfc_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .dbl_mode(dbl_mode), .wlen(wlen),
    .chars(chars), .rx_valid(rx_valid), .rx_data(rx_data), .fifo_wr_en(fifo_wr_en),
    .rx_state(rx_state), .suspended(suspended), .permit_q(permit_q), .tx_busy(tx_busy),
    .flow_flag(flow_flag), .inj_req(inj_req), .inj_ack(inj_ack), .cfg_we(cfg_we),
    .inj_data(inj_data)
);

// File: tb/test_swfc_engine.sv
`timescale 1ns/100ps
module test_swfc_engine;
    localparam int LVL_W = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sw_en = 0, dbl_mode = 0, spec_en = 0, auto_en = 0, int_en = 0;
    logic [1:0] wlen = 2'd3;
    logic cfg_we = 0;
    logic [1:0] cfg_sel = 0;
    logic [7:0] cfg_wdata = 0;
    logic rx_valid = 0;
    logic [7:0] rx_data = 0;
    logic [LVL_W-1:0] fifo_level = 0, halt_lvl = 7'd48, resume_lvl = 7'd16;
    logic tx_busy = 0, inj_ack = 0;
    logic fifo_wr_en, tx_permit, inj_req, flow_flag, irq;
    logic [7:0] fifo_wr_data, inj_data;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    swfc_engine #(.LVL_W(LVL_W)) i_swfc_engine (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr_cfg(input logic [1:0] sel, input logic [7:0] d);
        tick(); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        tick(); cfg_we = 0;
    endtask

    // driver: push expected FIFO writes, then strobe the character
    task automatic send_char(input logic [7:0] d, input bit pass);
        if (pass) exp_q.push_back(d);
        tick(); rx_valid = 1; rx_data = d;
        tick(); rx_valid = 0;
    endtask

    // monitor: every FIFO write must match the queue head
    always @(negedge clk) begin
        if (rst_n && fifo_wr_en) begin
            if (exp_q.size() == 0) chk(0, "R2 unexpected FIFO write", fifo_wr_data, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(fifo_wr_data == e, "R2/R4 FIFO data", fifo_wr_data, e);
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        chk(tx_permit == 1, "R1 reset permit", tx_permit, 1);
        chk(inj_req == 0, "R1 reset inj_req", inj_req, 0);
        chk(flow_flag == 0 && irq == 0, "R1 reset flag", flow_flag, 0);

        // R1 + R2 + R6: reset characters are 0x00, so 0x00 acts as Xoff
        sw_en = 1; int_en = 1;
        send_char(8'h00, 0);
        chk(flow_flag == 1, "R6 flag on xoff", flow_flag, 1);
        chk(irq == 1, "R6 irq", irq, 1);
        tick();
        chk(tx_permit == 0, "R1 reset xoff1=0 suspends", tx_permit, 0);
        int_en = 0; #0.1;
        chk(irq == 0, "R6 irq masked", irq, 0);
        wr_cfg(2'd0, 8'h11); wr_cfg(2'd1, 8'h12);
        wr_cfg(2'd2, 8'h13); wr_cfg(2'd3, 8'h14);
        send_char(8'h11, 0);
        chk(flow_flag == 0, "R6 flag cleared by xon", flow_flag, 0);
        tick();
        chk(tx_permit == 1, "R2 xon resumes", tx_permit, 1);
        send_char(8'h41, 1);
        send_char(8'h42, 1);

        // R5: suspension waits for the current character
        tx_busy = 1;
        send_char(8'h13, 0);
        tick(); tick();
        chk(tx_permit == 1, "R5 permit held while busy", tx_permit, 1);
        tx_busy = 0;
        tick();
        chk(tx_permit == 0, "R5 permit drops after char", tx_permit, 0);
        send_char(8'h11, 0);
        tick();
        chk(tx_permit == 1, "R5 resumed", tx_permit, 1);

        // R8: 5-bit word length masks upper bits
        wlen = 2'd0;
        send_char(8'hF3, 0);
        tick();
        chk(tx_permit == 0, "R8 masked xoff", tx_permit, 0);
        send_char(8'h71, 0);
        tick();
        chk(tx_permit == 1, "R8 masked xon", tx_permit, 1);
        wlen = 2'd3;
        send_char(8'hF3, 1);
        tick();
        chk(tx_permit == 1, "R8 8-bit no match", tx_permit, 1);

        // R3: double-character commands
        dbl_mode = 1;
        send_char(8'h13, 0);
        tick();
        chk(tx_permit == 1, "R3 one char not enough", tx_permit, 1);
        send_char(8'h14, 0);
        tick();
        chk(tx_permit == 0, "R3 pair suspends", tx_permit, 0);
        send_char(8'h11, 0);
        send_char(8'h12, 0);
        tick();
        chk(tx_permit == 1, "R3 pair resumes", tx_permit, 1);

        // R4: abandoned pair is forwarded in order
        send_char(8'h13, 1);
        send_char(8'h55, 1);
        tick(); tick();
        chk(tx_permit == 1, "R4 no suspend", tx_permit, 1);

        // R7: special character forwarded and flagged
        dbl_mode = 0; spec_en = 1;
        send_char(8'h14, 1);
        tick();
        chk(flow_flag == 1, "R7 special flag", flow_flag, 1);
        send_char(8'h11, 0);
        chk(flow_flag == 0, "R7 flag cleared", flow_flag, 0);
        spec_en = 0;

        // R12: disabled matching forwards everything
        sw_en = 0;
        send_char(8'h13, 1);
        tick(); tick();
        chk(tx_permit == 1, "R12 no suspend", tx_permit, 1);

        // R9 + R11: halt threshold crossing, double mode
        dbl_mode = 1; auto_en = 1; fifo_level = 7'd10;
        tick(); tick();
        chk(inj_req == 0, "R9 below halt", inj_req, 0);
        fifo_level = 7'd50;
        tick();
        chk(inj_req == 1 && inj_data == 8'h13, "R9 xoff1 injected", inj_data, 8'h13);
        chk(tx_permit == 0, "R11 FIFO data held back", tx_permit, 0);
        tx_busy = 1; #0.1;
        chk(inj_req == 0, "R11 no inj while busy", inj_req, 0);
        tick(); tx_busy = 0; #0.1;
        chk(inj_req == 1 && inj_data == 8'h13, "R9 still pending", inj_data, 8'h13);
        inj_ack = 1; tick(); inj_ack = 0;
        chk(inj_req == 1 && inj_data == 8'h14, "R9 xoff2 injected", inj_data, 8'h14);
        inj_ack = 1; tick(); inj_ack = 0;
        chk(inj_req == 0, "R9 sequence done", inj_req, 0);
        tick(); tick(); tick();
        chk(inj_req == 0, "R9 only once", inj_req, 0);
        chk(tx_permit == 1, "R11 permit back", tx_permit, 1);

        // R10: resume threshold
        fifo_level = 7'd30; tick(); tick();
        chk(inj_req == 0, "R10 above resume", inj_req, 0);
        fifo_level = 7'd16;
        tick();
        chk(inj_req == 1 && inj_data == 8'h11, "R10 xon1", inj_data, 8'h11);
        inj_ack = 1; tick(); inj_ack = 0;
        chk(inj_req == 1 && inj_data == 8'h12, "R10 xon2", inj_data, 8'h12);
        inj_ack = 1; tick(); inj_ack = 0;
        chk(inj_req == 0, "R10 done", inj_req, 0);

        // R9: single mode sends only Xoff1
        dbl_mode = 0; fifo_level = 7'd60;
        tick();
        chk(inj_data == 8'h13 && inj_req == 1, "R9 single xoff1", inj_data, 8'h13);
        inj_ack = 1; tick(); inj_ack = 0;
        chk(inj_req == 0, "R9 single one char", inj_req, 0);

        tick(); tick();
        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule